// File: doc/BRIEF.md
# Segmented Cartridge-to-Memory DMA Sequencer

This block is the control path of a DMA engine. It moves data from a 16-bit cartridge-side bus into a 64-bit-wide main memory. Software loads a memory address, a cartridge address and a length. Writing the length starts a transfer. The sequencer splits the transfer into blocks and sizes each one. For each block it drives a fill phase, in which the datapath fetches 16-bit beats from the cartridge into a staging buffer. It then drives a drain phase, in which the datapath writes the buffer to memory. During these phases it advances both address registers. When the last block has drained, the block drops its busy flag.

Block size is the smallest of three values: the bytes still to move, the bytes left in the current 2 KiB memory page, and the free room in the 128-byte buffer. In the opening block, the buffer is filled from an index equal to the memory address misalignment, and the memory address is rounded up to an 8-byte boundary afterwards. Every later block therefore starts aligned. Because both address registers keep their final values, a second length write continues the previous transfer where it stopped.

Top module: `cart_dma_seq`

## Requirements
- R1: The length register holds the byte count minus one. A write of it (cfg_sel = 2) while idle starts a transfer: busy is high from the next cycle until the drain of the last block is acknowledged.
- R2: Writes to the memory address (cfg_sel = 0) and the cartridge address (cfg_sel = 1) store the written value with bit 0 forced to zero, so both address outputs are always even.
- R3: Each block size (blk_size) is the minimum of the remaining byte count, 2048 minus memory address bits [10:0], and 128 minus blk_idx.
- R4: The first block of a transfer has blk_idx equal to memory address bits [2:0] (0, 2, 4 or 6). Every later block has blk_idx 0.
- R5: A block needs ceil(blk_size/2) cartridge beats. Each cartridge_rd_ack accepted during fill adds 2 to the cartridge address.
- R6: Fill and drain never overlap. drain_active rises only after the last beat of the block is acknowledged, and the memory address does not change during fill.
- R7: When the first block drains, the memory address becomes the start address plus blk_size, rounded up to the next multiple of 8.
- R8: When a later block drains, the memory address advances by blk_size rounded up to an even count.
- R9: A length write after completion starts a follow-up transfer from the current values of both address registers.
- R10: After a transfer, the length readback is 0x7F. If the transfer was shorter than 8 bytes, it is 0x7F minus the starting misalignment.
- R11: While busy, writes to any register are ignored. They change neither the addresses, the length readback, nor the block sequence, and they do not restart the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 memory address, 1 cartridge address, 2 length |
| cfg_wdata | input | DATA_W | Register write data |
| mem_addr | output | ADDR_W | Current memory address |
| cart_addr | output | CART_W | Current cartridge address |
| len_rd | output | LEN_W | Length register readback |
| busy | output | 1 | Transfer in progress |
| fill_active | output | 1 | Current block is being fetched from the cartridge |
| blk_idx | output | 16 | Buffer start index of the current block |
| blk_size | output | 16 | Byte count of the current block |
| cart_rd_ack | input | 1 | One 16-bit cartridge beat accepted |
| drain_active | output | 1 | Buffer is being written to memory |
| drain_done | input | 1 | Drain of the current block finished |

## Verification
The hardest case to reach from the ports is a transfer whose first block is cut short by a page end while the start address is misaligned. In that case the page limit, the misalignment offset and the rounding up to 8 bytes all act in one block. The bench starts a 6-byte transfer two bytes below a page boundary at misalignment 6, which also makes the length readback take its short-transfer value. A 128-byte-plus-one transfer, followed by a follow-up with no address write, drives an odd tail block and then a misaligned restart.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_FILL  = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [15:0] idx;
        logic [15:0] size;
        logic [15:0] beats;
    } blk_t;

    localparam logic [1:0] SEL_MEM  = 2'd0;
    localparam logic [1:0] SEL_CART = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;

    function automatic logic [15:0] beats_of(input logic [15:0] sz);
        return (sz + 16'd1) >> 1;
    endfunction

endpackage

// File: rtl/cdma_blk_calc.sv
module cdma_blk_calc
    import cdma_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int PAGE_BYTES = 2048,
    parameter int BUF_BYTES  = 128,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int CW        = LEN_W + 1
) (
    input  logic [CW-1:0]     rem,
    input  logic [PAGE_W-1:0] page_off,
    input  logic [2:0]        start_idx,
    output blk_t              blk
);
    logic [CW-1:0] page_left;
    logic [CW-1:0] buf_left;
    logic [CW-1:0] lim_a;
    logic [CW-1:0] lim_b;

    always_comb begin
        page_left = CW'(PAGE_BYTES) - CW'(page_off);
        buf_left  = CW'(BUF_BYTES) - CW'(start_idx);
        lim_a     = (rem < page_left) ? rem : page_left;
        lim_b     = (lim_a < buf_left) ? lim_a : buf_left;
        blk.idx   = 16'(start_idx);
        blk.size  = 16'(lim_b);
        blk.beats = beats_of(16'(lim_b));
    end
endmodule

// File: rtl/cdma_beat_cnt.sv
module cdma_beat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cart_dma_seq.sv
module cart_dma_seq
    import cdma_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int CART_W     = 32,
    parameter int LEN_W      = 24,
    parameter int PAGE_BYTES = 2048,
    parameter int BUF_BYTES  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CART_W-1:0] cart_addr,
    output logic [LEN_W-1:0]  len_rd,
    output logic              busy,
    output logic              fill_active,
    output logic [15:0]       blk_idx,
    output logic [15:0]       blk_size,
    input  logic              cart_rd_ack,
    output logic              drain_active,
    input  logic              drain_done
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int CW     = LEN_W + 1;

    seq_state_t        state_q;
    logic [ADDR_W-1:0] mem_q;
    logic [CART_W-1:0] cart_q;
    logic [LEN_W-1:0]  len_q;
    logic [CW-1:0]     rem_q;
    logic              first_q;
    logic              short_q;
    logic [2:0]        mis_q;
    blk_t              blk_q;
    blk_t              blk_nxt;
    logic [2:0]        start_idx;
    logic              beat_last;
    logic              beat_take;
    logic              idle_wr;
    logic [CW-1:0]     new_rem;
    logic [ADDR_W-1:0] mem_sum;

    assign idle_wr   = cfg_we && (state_q == ST_IDLE);
    assign new_rem   = CW'(cfg_wdata[LEN_W-1:0]) + CW'(1);
    assign start_idx = first_q ? mem_q[2:0] : 3'd0;
    assign beat_take = (state_q == ST_FILL) && cart_rd_ack;
    assign mem_sum   = mem_q + ADDR_W'(blk_q.size);

    cdma_blk_calc #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BUF_BYTES  (BUF_BYTES)
    ) calc_i (
        .rem       (rem_q),
        .page_off  (mem_q[PAGE_W-1:0]),
        .start_idx (start_idx),
        .blk       (blk_nxt)
    );

    cdma_beat_cnt #(
        .CNT_W (16)
    ) beats_i (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_CALC),
        .load_val (blk_nxt.beats),
        .dec      (beat_take),
        .last     (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mem_q   <= '0;
            cart_q  <= '0;
            len_q   <= '0;
            rem_q   <= '0;
            first_q <= 1'b0;
            short_q <= 1'b0;
            mis_q   <= 3'd0;
            blk_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (idle_wr) begin
                        case (cfg_sel)
                            SEL_MEM:  mem_q  <= cfg_wdata[ADDR_W-1:0] & ~ADDR_W'(1);
                            SEL_CART: cart_q <= cfg_wdata[CART_W-1:0] & ~CART_W'(1);
                            SEL_LEN: begin
                                len_q   <= cfg_wdata[LEN_W-1:0];
                                rem_q   <= new_rem;
                                first_q <= 1'b1;
                                short_q <= (new_rem < CW'(8));
                                mis_q   <= mem_q[2:0];
                                state_q <= ST_CALC;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_CALC: begin
                    blk_q   <= blk_nxt;
                    state_q <= ST_FILL;
                end
                ST_FILL: begin
                    if (cart_rd_ack) begin
                        cart_q <= cart_q + CART_W'(2);
                        if (beat_last) begin
                            state_q <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (drain_done) begin
                        if (first_q) begin
                            mem_q <= (mem_sum + ADDR_W'(7)) & ~ADDR_W'(7);
                        end else begin
                            mem_q <= (mem_sum + ADDR_W'(1)) & ~ADDR_W'(1);
                        end
                        first_q <= 1'b0;
                        rem_q   <= rem_q - CW'(blk_q.size);
                        if (rem_q == CW'(blk_q.size)) begin
                            state_q <= ST_IDLE;
                            len_q   <= short_q ? (LEN_W'(BUF_BYTES - 1) - LEN_W'(mis_q))
                                               : LEN_W'(BUF_BYTES - 1);
                        end else begin
                            state_q <= ST_CALC;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_addr     = mem_q;
    assign cart_addr    = cart_q;
    assign len_rd       = len_q;
    assign busy         = (state_q != ST_IDLE);
    assign fill_active  = (state_q == ST_FILL);
    assign drain_active = (state_q == ST_DRAIN);
    assign blk_idx      = blk_q.idx;
    assign blk_size     = blk_q.size;
endmodule

// File: rtl/cdma_seq_chk.sv
module cdma_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int CART_W     = 32,
    parameter int PAGE_BYTES = 2048,
    parameter int BUF_BYTES  = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CART_W-1:0] cart_addr,
    input logic              busy,
    input logic              fill_active,
    input logic              drain_active,
    input logic [15:0]       blk_idx,
    input logic [15:0]       blk_size,
    input logic              cart_rd_ack
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fill_active && drain_active)); // R6

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        fill_active |-> (blk_idx <= 16'd6 && blk_idx[0] == 1'b0)); // R4

    AST_SIZE_BUF: assert property (@(posedge clk) disable iff (rst)
        fill_active |-> (blk_size != 16'd0 && 32'(blk_size) + 32'(blk_idx) <= BUF_BYTES)); // R3

    AST_SIZE_PAGE: assert property (@(posedge clk) disable iff (rst)
        fill_active |-> (32'(blk_size) <= PAGE_BYTES - 32'(mem_addr[PAGE_W-1:0]))); // R3

    AST_CART_STEP: assert property (@(posedge clk) disable iff (rst)
        (fill_active && cart_rd_ack) |=> (cart_addr == $past(cart_addr) + CART_W'(2))); // R5

    AST_MEM_HOLD_FILL: assert property (@(posedge clk) disable iff (rst)
        fill_active |=> (mem_addr == $past(mem_addr))); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we && !drain_active) |=> busy); // R11

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (mem_addr[0] == 1'b0 && cart_addr[0] == 1'b0)); // R2

    AST_FILL_BUSY: assert property (@(posedge clk) disable iff (rst)
        (fill_active || drain_active) |-> busy); // R1
endmodule

bind cart_dma_seq cdma_seq_chk #(
    .ADDR_W     (ADDR_W),
    .CART_W     (CART_W),
    .PAGE_BYTES (PAGE_BYTES),
    .BUF_BYTES  (BUF_BYTES)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .mem_addr     (mem_addr),
    .cart_addr    (cart_addr),
    .busy         (busy),
    .fill_active  (fill_active),
    .drain_active (drain_active),
    .blk_idx      (blk_idx),
    .blk_size     (blk_size),
    .cart_rd_ack  (cart_rd_ack)
);

// File: tb/cart_dma_seq_tb_top.sv
module cart_dma_seq_tb_top;
    localparam int N_VEC = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] mem_addr;
    logic [31:0] cart_addr;
    logic [23:0] len_rd;
    logic        busy;
    logic        fill_active;
    logic [15:0] blk_idx;
    logic [15:0] blk_size;
    logic        cart_rd_ack = 1'b0;
    logic        drain_active;
    logic        drain_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cart_dma_seq dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .mem_addr     (mem_addr),
        .cart_addr    (cart_addr),
        .len_rd       (len_rd),
        .busy         (busy),
        .fill_active  (fill_active),
        .blk_idx      (blk_idx),
        .blk_size     (blk_size),
        .cart_rd_ack  (cart_rd_ack),
        .drain_active (drain_active),
        .drain_done   (drain_done)
    );

    // {set_addr, mem, cart, len, exp_mem, exp_cart, exp_blocks, exp_readback}
    typedef struct packed {
        logic        set_addr;
        logic [31:0] mem;
        logic [31:0] cart;
        logic [23:0] len;
        logic [31:0] exp_mem;
        logic [31:0] exp_cart;
        logic [7:0]  exp_blk;
        logic [23:0] exp_rb;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 32'h100,   32'h1000_1000, 24'h7F, 32'h180,   32'h1000_1080, 8'd1, 24'h7F},
        '{1'b1, 32'h106,   32'h1000_1000, 24'hFF, 32'h206,   32'h1000_1100, 8'd3, 24'h7F},
        '{1'b1, 32'h147E0, 32'h1000_1000, 24'hFF, 32'h148E0, 32'h1000_1100, 8'd3, 24'h7F},
        '{1'b1, 32'h104,   32'h1000_1000, 24'h02, 32'h108,   32'h1000_1004, 8'd1, 24'h7B},
        '{1'b1, 32'h100,   32'h1000_1000, 24'h80, 32'h182,   32'h1000_1082, 8'd2, 24'h7F},
        '{1'b0, 32'h0,     32'h0,         24'h07, 32'h190,   32'h1000_108A, 8'd1, 24'h7F},
        '{1'b1, 32'h7FE,   32'h1000_1000, 24'h05, 32'h804,   32'h1000_1006, 8'd2, 24'h79}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Serve fill/drain for every block and check each against a model built
    // from the block-sizing rules (R3, R4) and address rules (R5..R8).
    task automatic serve(output int nblk);
        int rem;
        int mm;
        bit first;
        nblk  = 0;
        first = 1'b1;
        mm    = int'(mem_addr);
        rem   = int'(cfg_wdata[23:0]) + 1;
        while (1) begin
            int t;
            int idx;
            int sz;
            int beats;
            logic [31:0] c0;
            logic [31:0] m0;
            t = 0;
            while (!fill_active && busy && t < 1000) begin
                @(negedge clk);
                t++;
            end
            if (!busy) break;
            idx = first ? (mm % 8) : 0;
            sz  = rem;
            if (2048 - (mm % 2048) < sz) sz = 2048 - (mm % 2048);
            if (128 - idx < sz) sz = 128 - idx;
            check(blk_idx == 16'(idx), "R4 block start index", 32'(blk_idx), 32'(idx));
            check(blk_size == 16'(sz), "R3 block size", 32'(blk_size), 32'(sz));
            beats = (sz + 1) / 2;
            c0 = cart_addr;
            m0 = mem_addr;
            for (int i = 0; i < beats; i++) begin
                cart_rd_ack = 1'b1;
                @(negedge clk);
                if (i < beats - 1 && !fill_active) begin
                    check(1'b0, "R6 fill ended early", 32'(i), 32'(beats));
                end
            end
            cart_rd_ack = 1'b0;
            check(drain_active && !fill_active, "R6 drain after last beat",
                  32'(drain_active), 32'd1);
            check(cart_addr == c0 + 32'(2 * beats), "R5 cartridge advance",
                  cart_addr, c0 + 32'(2 * beats));
            check(mem_addr == m0, "R6 memory held during fill", mem_addr, m0);
            drain_done = 1'b1;
            @(negedge clk);
            drain_done = 1'b0;
            if (first) mm = ((mm + sz + 7) / 8) * 8;   // R7
            else       mm = ((mm + sz + 1) / 2) * 2;   // R8
            check(mem_addr == 32'(mm), first ? "R7 first block round-up" : "R8 later block advance",
                  mem_addr, 32'(mm));
            rem  -= sz;
            first = 1'b0;
            nblk++;
        end
    endtask

    initial begin
        int nb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !fill_active && !drain_active, "R1 idle after reset", 32'(busy), 32'd0);
        check(mem_addr == 0 && cart_addr == 0, "R1 addresses cleared", mem_addr, 32'd0);

        // R2 bit 0 forced to zero
        write_reg(2'd0, 32'h123);
        check(mem_addr == 32'h122, "R2 memory address even", mem_addr, 32'h122);
        write_reg(2'd1, 32'h1000_0001);
        check(cart_addr == 32'h1000_0000, "R2 cartridge address even", cart_addr, 32'h1000_0000);

        // Vector table: R1, R3..R10 (entry 5 is the R9 follow-up)
        for (int v = 0; v < N_VEC; v++) begin
            if (VECS[v].set_addr) begin
                write_reg(2'd0, VECS[v].mem);
                write_reg(2'd1, VECS[v].cart);
            end
            write_reg(2'd2, 32'(VECS[v].len));
            check(busy, "R1 busy after length write", 32'(busy), 32'd1);
            serve(nb);
            check(!busy, "R1 idle after last drain", 32'(busy), 32'd0);
            check(nb == int'(VECS[v].exp_blk), "R3 block count", 32'(nb), 32'(VECS[v].exp_blk));
            check(mem_addr == VECS[v].exp_mem,
                  VECS[v].set_addr ? "R7 final memory address" : "R9 follow-up memory address",
                  mem_addr, VECS[v].exp_mem);
            check(cart_addr == VECS[v].exp_cart,
                  VECS[v].set_addr ? "R5 final cartridge address" : "R9 follow-up cartridge address",
                  cart_addr, VECS[v].exp_cart);
            check(len_rd == VECS[v].exp_rb, "R10 length readback",
                  32'(len_rd), 32'(VECS[v].exp_rb));
        end

        // R11: writes during a transfer are ignored
        write_reg(2'd0, 32'h200);
        write_reg(2'd1, 32'h2000_0000);
        write_reg(2'd2, 32'h0F);
        while (!fill_active) @(negedge clk);
        write_reg(2'd2, 32'h05);
        write_reg(2'd0, 32'h300);
        write_reg(2'd1, 32'h4000_0000);
        check(mem_addr == 32'h200, "R11 memory address write ignored", mem_addr, 32'h200);
        check(cart_addr == 32'h2000_0000, "R11 cartridge address write ignored",
              cart_addr, 32'h2000_0000);
        check(len_rd == 24'h0F, "R11 length write ignored", 32'(len_rd), 32'h0F);
        cfg_wdata = 32'h0F;
        serve(nb);
        check(nb == 1, "R11 block sequence unchanged", 32'(nb), 32'd1);
        check(mem_addr == 32'h210, "R11 final memory address", mem_addr, 32'h210);
        check(cart_addr == 32'h2000_0010, "R11 final cartridge address",
              cart_addr, 32'h2000_0010);
        repeat (5) @(negedge clk);
        check(!busy, "R11 no restart", 32'(busy), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule